// File: doc/BRIEF.md
# Destination Address Filter

This block decides, for each received frame, whether the frame is kept or dropped, using only the 48-bit destination address. The address arrives already extracted from the frame, together with a one-cycle valid strobe. The block compares it in parallel against a bank of programmable address entries. Each entry has its own enable bit. A small command register can accept whole address classes (unicast, multicast, broadcast), turn entry comparison on or off, and invert the comparison result.

Software programs the entries, the enable mask and the command register through a simple write port with a combinational read-back. One clock after each valid strobe the block gives exactly one of two pulses, accept or reject. With the decision it reports whether an enabled entry matched and which one.

Top module: `addr_filter`

## Requirements
- R1: After reset every entry, the enable mask and the command register read as zero, and neither accept nor reject is asserted.
- R2: Entry i occupies two 32-bit words at byte offsets 8*i (high) and 8*i+4 (low). The high word holds address bytes 0..3 with byte 0 (the first byte on the wire, address bits 47:40) in bits 31:24. The low word holds bytes 4..5 in bits 31:16. Reading a low word returns zero in bits 15:0 whatever was written there.
- R3: The enable word sits at byte offset 8*N_ENT (0x80 by default). Bit i enables entry i, and a disabled entry never matches. Bits above N_ENT read as zero.
- R4: The command word sits at byte offset 8*N_ENT+4 (0x84 by default). Bit 0 accepts every unicast address, bit 1 every multicast address, bit 2 the broadcast address, bit 3 inverts the entry comparison result and bit 4 enables entry comparison. Bits 31:5 read as zero.
- R5: The cycle after da_valid is high, exactly one of accept and reject is high. In every other cycle both are low.
- R6: With comparison enabled and inversion off, an address equal to any enabled entry is accepted.
- R7: With comparison and inversion both enabled, an address that matches an enabled entry is rejected unless its class bit accepts it, and an address that matches none is accepted.
- R8: With comparison disabled the entries have no effect: the frame is accepted only through its class bit.
- R9: The all-ones address is broadcast. Any other address with bit 40 set (bit 0 of byte 0) is multicast. An address with bit 40 clear is unicast. An address whose class bit is set is accepted whatever the entries say.
- R10: match_hit and match_idx update with each decision. match_idx is the lowest-numbered enabled entry equal to the address, and match_hit is 1 when such an entry exists. With no match both are zero. Between decisions they hold their values.
- R11: A write to an offset that is not 4-byte aligned, or beyond the command word, changes nothing. A read of such an offset returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| da_valid | input | 1 | Destination address strobe, one cycle per frame |
| da_addr | input | 48 | Destination address, byte 0 in bits 47:40 |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | AW (8) | Register byte offset, shared by write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| accept | output | 1 | Frame accepted, one cycle after da_valid |
| reject | output | 1 | Frame dropped, one cycle after da_valid |
| match_hit | output | 1 | An enabled entry matched the last address |
| match_idx | output | log2(N_ENT) (4) | Lowest matching enabled entry |

## Verification
The properties assume that da_valid is a single-cycle strobe whose address is stable in that cycle. They also assume that no register write lands in the same cycle as a strobe, because the decision uses the configuration already held in that cycle. The stimulus meets both conditions. It drives each address for one cycle, with valid dropped between frames, and it performs all register writes on their own cycles between frames. Random addresses are drawn so that many of them hit programmed entries, fall in the broadcast or multicast classes, or match several entries at once.

// File: rtl/addr_filter_pkg.sv
package addr_filter_pkg;

  localparam int MAC_W = 48;
  localparam int REG_W = 32;
  localparam int LO_W  = MAC_W - REG_W;
  localparam int CMD_W = 5;

  localparam int CMD_UNI  = 0;
  localparam int CMD_MUL  = 1;
  localparam int CMD_BRD  = 2;
  localparam int CMD_INV  = 3;
  localparam int CMD_CMP  = 4;

  typedef enum logic [1:0] {
    CLS_UNI   = 2'd0,
    CLS_MULTI = 2'd1,
    CLS_BCAST = 2'd2
  } frame_cls_e;

  function automatic frame_cls_e classify(input logic [MAC_W-1:0] d);
    if (&d)             return CLS_BCAST;
    else if (d[MAC_W-8]) return CLS_MULTI;
    else                return CLS_UNI;
  endfunction

  function automatic logic class_ok(input frame_cls_e c, input logic [CMD_W-1:0] cmd);
    case (c)
      CLS_BCAST: return cmd[CMD_BRD];
      CLS_MULTI: return cmd[CMD_MUL];
      default:   return cmd[CMD_UNI];
    endcase
  endfunction

  function automatic logic cam_ok(input logic hit, input logic [CMD_W-1:0] cmd);
    return cmd[CMD_CMP] & (hit ^ cmd[CMD_INV]);
  endfunction

endpackage

// File: rtl/addr_filter_regs.sv
module addr_filter_regs
  import addr_filter_pkg::*;
#(
  parameter int N_ENT = 16,
  parameter int AW    = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          reg_wr,
  input  logic [AW-1:0]                 reg_addr,
  input  logic [REG_W-1:0]              reg_wdata,
  output logic [REG_W-1:0]              reg_rdata,
  output logic [N_ENT-1:0][MAC_W-1:0]   ent_addr,
  output logic [N_ENT-1:0]              ent_en,
  output logic [CMD_W-1:0]              cmd
);

  localparam int WW       = AW - 2;
  localparam int ENA_WORD = 2 * N_ENT;
  localparam int CMD_WORD = 2 * N_ENT + 1;

  logic [WW-1:0]    word;
  logic             aligned;
  logic [N_ENT-1:0] sel_hi;
  logic [N_ENT-1:0] sel_lo;
  logic             sel_en;
  logic             sel_cmd;

  assign word    = reg_addr[AW-1:2];
  assign aligned = (reg_addr[1:0] == 2'b00);
  assign sel_en  = aligned && (word == WW'(ENA_WORD));
  assign sel_cmd = aligned && (word == WW'(CMD_WORD));

  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    logic [REG_W-1:0] hi_q;
    logic [LO_W-1:0]  lo_q;

    assign sel_hi[i] = aligned && (word == WW'(2 * i));
    assign sel_lo[i] = aligned && (word == WW'(2 * i + 1));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hi_q <= '0;
        lo_q <= '0;
      end else if (reg_wr) begin
        if (sel_hi[i]) hi_q <= reg_wdata;
        if (sel_lo[i]) lo_q <= reg_wdata[REG_W-1:REG_W-LO_W];
      end
    end

    assign ent_addr[i] = {hi_q, lo_q};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_en <= '0;
      cmd    <= '0;
    end else if (reg_wr) begin
      if (sel_en)  ent_en <= reg_wdata[N_ENT-1:0];
      if (sel_cmd) cmd    <= reg_wdata[CMD_W-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < N_ENT; i++) begin
      if (sel_hi[i]) reg_rdata = ent_addr[i][MAC_W-1:LO_W];
      if (sel_lo[i]) reg_rdata = {ent_addr[i][LO_W-1:0], {(REG_W-LO_W){1'b0}}};
    end
    if (sel_en)  reg_rdata = REG_W'(ent_en);
    if (sel_cmd) reg_rdata = REG_W'(cmd);
  end

endmodule

// File: rtl/addr_filter_cam.sv
module addr_filter_cam
  import addr_filter_pkg::*;
#(
  parameter int N_ENT = 16
) (
  input  logic [MAC_W-1:0]              da,
  input  logic [N_ENT-1:0][MAC_W-1:0]   ent_addr,
  input  logic [N_ENT-1:0]              ent_en,
  output logic                          hit,
  output logic [$clog2(N_ENT)-1:0]      idx
);

  localparam int IDX_W = $clog2(N_ENT);

  logic [N_ENT-1:0] eq;

  for (genvar i = 0; i < N_ENT; i++) begin : g_cmp
    assign eq[i] = ent_en[i] && (ent_addr[i] == da);
  end

  always_comb begin
    idx = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (eq[i]) idx = IDX_W'(i);
    end
  end

  assign hit = |eq;

endmodule

// File: rtl/addr_filter_decide.sv
module addr_filter_decide
  import addr_filter_pkg::*;
#(
  parameter int N_ENT = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       da_valid,
  input  logic [MAC_W-1:0]           da,
  input  logic [CMD_W-1:0]           cmd,
  input  logic                       cam_hit,
  input  logic [$clog2(N_ENT)-1:0]   cam_idx,
  output logic                       cls_accept,
  output logic                       accept,
  output logic                       reject,
  output logic                       match_hit,
  output logic [$clog2(N_ENT)-1:0]   match_idx
);

  frame_cls_e cls;
  logic       cam_accept;
  logic       take;

  assign cls        = classify(da);
  assign cls_accept = class_ok(cls, cmd);
  assign cam_accept = cam_ok(cam_hit, cmd);
  assign take       = cls_accept | cam_accept;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      accept    <= 1'b0;
      reject    <= 1'b0;
      match_hit <= 1'b0;
      match_idx <= '0;
    end else begin
      accept <= da_valid & take;
      reject <= da_valid & ~take;
      if (da_valid) begin
        match_hit <= cam_hit;
        match_idx <= cam_idx;
      end
    end
  end

endmodule

// File: rtl/addr_filter.sv
module addr_filter
  import addr_filter_pkg::*;
#(
  parameter int N_ENT = 16,
  parameter int AW    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       da_valid,
  input  logic [47:0]                da_addr,
  input  logic                       reg_wr,
  input  logic [AW-1:0]              reg_addr,
  input  logic [31:0]                reg_wdata,
  output logic [31:0]                reg_rdata,
  output logic                       accept,
  output logic                       reject,
  output logic                       match_hit,
  output logic [$clog2(N_ENT)-1:0]   match_idx
);

  logic [N_ENT-1:0][MAC_W-1:0] ent_addr_q;
  logic [N_ENT-1:0]            ent_en_q;
  logic [CMD_W-1:0]            cmd_q;
  logic                        cam_hit;
  logic [$clog2(N_ENT)-1:0]    cam_idx;
  logic                        cls_accept;

  addr_filter_regs #(.N_ENT(N_ENT), .AW(AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .ent_addr  (ent_addr_q),
    .ent_en    (ent_en_q),
    .cmd       (cmd_q)
  );

  addr_filter_cam #(.N_ENT(N_ENT)) u_cam (
    .da       (da_addr),
    .ent_addr (ent_addr_q),
    .ent_en   (ent_en_q),
    .hit      (cam_hit),
    .idx      (cam_idx)
  );

  addr_filter_decide #(.N_ENT(N_ENT)) u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .da_valid   (da_valid),
    .da         (da_addr),
    .cmd        (cmd_q),
    .cam_hit    (cam_hit),
    .cam_idx    (cam_idx),
    .cls_accept (cls_accept),
    .accept     (accept),
    .reject     (reject),
    .match_hit  (match_hit),
    .match_idx  (match_idx)
  );

endmodule

// File: rtl/addr_filter_chk.sv
module addr_filter_chk
  import addr_filter_pkg::*;
#(
  parameter int N_ENT = 16,
  parameter int AW    = 8
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      da_valid,
  input logic [AW-1:0]             reg_addr,
  input logic [31:0]               reg_rdata,
  input logic                      accept,
  input logic                      reject,
  input logic                      match_hit,
  input logic [$clog2(N_ENT)-1:0]  match_idx,
  input logic [N_ENT-1:0]          ent_en_q,
  input logic [CMD_W-1:0]          cmd_q,
  input logic                      cam_hit,
  input logic [$clog2(N_ENT)-1:0]  cam_idx,
  input logic                      cls_accept
);

  localparam int ENA_OFF = 8 * N_ENT;

  a_r5_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    da_valid |=> (accept ^ reject));

  a_r5_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !da_valid |=> (!accept && !reject));

  a_r6_cam_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && cam_hit && cmd_q[CMD_CMP] && !cmd_q[CMD_INV]) |=> accept);

  a_r7_inverted_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && cam_hit && cmd_q[CMD_CMP] && cmd_q[CMD_INV] && !cls_accept) |=> reject);

  a_r8_no_compare: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && !cmd_q[CMD_CMP] && !cls_accept) |=> reject);

  a_r9_class_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && cls_accept) |=> accept);

  a_r3_enabled_only: assert property (@(posedge clk) disable iff (!rst_n)
    cam_hit |-> ent_en_q[cam_idx]);

  a_r10_idx_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !match_hit |-> (match_idx == '0));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !da_valid |=> ($stable(match_idx) && $stable(match_hit)));

  a_r2_low_pad: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_addr < AW'(ENA_OFF)) && (reg_addr[2:0] == 3'b100)) |-> (reg_rdata[15:0] == 16'h0));

endmodule

bind addr_filter addr_filter_chk #(.N_ENT(N_ENT), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .da_valid   (da_valid),
  .reg_addr   (reg_addr),
  .reg_rdata  (reg_rdata),
  .accept     (accept),
  .reject     (reject),
  .match_hit  (match_hit),
  .match_idx  (match_idx),
  .ent_en_q   (ent_en_q),
  .cmd_q      (cmd_q),
  .cam_hit    (cam_hit),
  .cam_idx    (cam_idx),
  .cls_accept (cls_accept)
);

// File: tb/addr_filter_test.sv
`timescale 1ns/1ps
module addr_filter_test;

  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        da_valid = 1'b0;
  logic [47:0] da_addr = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        accept, reject, match_hit;
  logic [3:0]  match_idx;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [31:0] hi_m [N];
  logic [15:0] lo_m [N];
  logic [15:0] en_m;
  logic [4:0]  cmd_m;

  always #4 clk = ~clk;

  addr_filter uut (
    .clk(clk), .rst_n(rst_n), .da_valid(da_valid), .da_addr(da_addr),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .accept(accept), .reject(reject),
    .match_hit(match_hit), .match_idx(match_idx)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit m_hit(input logic [47:0] d);
    for (int i = 0; i < N; i++) if (en_m[i] && {hi_m[i], lo_m[i]} == d) return 1;
    return 0;
  endfunction

  function automatic logic [3:0] m_idx(input logic [47:0] d);
    for (int i = 0; i < N; i++) if (en_m[i] && {hi_m[i], lo_m[i]} == d) return 4'(i);
    return 4'd0;
  endfunction

  function automatic bit m_accept(input logic [47:0] d);
    bit bc, mc, cls_ok, cam;
    bc = (d == 48'hFFFF_FFFF_FFFF);
    mc = !bc && d[40];
    cls_ok = bc ? cmd_m[2] : (mc ? cmd_m[1] : cmd_m[0]);
    cam = cmd_m[4] && (m_hit(d) != cmd_m[3]);
    return cls_ok || cam;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] v);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = v;
    @(negedge clk);
    reg_wr = 0;
    if (a[1:0] == 2'b00) begin
      if (a < 8'h80) begin
        if (a[2]) lo_m[a[6:3]] = v[31:16];
        else      hi_m[a[6:3]] = v;
      end else if (a == 8'h80) en_m = v[15:0];
      else if (a == 8'h84) cmd_m = v[4:0];
    end
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(reg_rdata == exp, req, 64'(reg_rdata), 64'(exp));
  endtask

  task automatic send(input logic [47:0] d, input string req);
    bit ea;
    logic [3:0] ei;
    bit eh;
    ea = m_accept(d); eh = m_hit(d); ei = m_idx(d);
    @(negedge clk);
    da_valid = 1; da_addr = d;
    @(negedge clk);
    da_valid = 0;
    chk(accept == ea && reject == !ea, req, {62'd0, accept, reject}, {62'd0, ea, !ea});
    chk(match_hit == eh && match_idx == ei, "R10", {59'd0, match_hit, match_idx}, {59'd0, eh, ei});
  endtask

  task automatic set_entry(input int i, input logic [47:0] d);
    wr(8'(8 * i), d[47:16]);
    wr(8'(8 * i + 4), {d[15:0], 16'hA5C3});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [47:0] a;
    void'($urandom(32'h1F2E3D4C));
    for (int i = 0; i < N; i++) begin hi_m[i] = '0; lo_m[i] = '0; end
    en_m = '0; cmd_m = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    chk(!accept && !reject, "R1", {62'd0, accept, reject}, 64'd0);
    rd(8'h00, 32'h0, "R1");
    rd(8'h7C, 32'h0, "R1");
    rd(8'h80, 32'h0, "R1");
    rd(8'h84, 32'h0, "R1");
    send(48'h0200_0000_0001, "R1");

    // R2 layout
    set_entry(3, 48'h0211_2233_4455);
    rd(8'h18, 32'h0211_2233, "R2");
    rd(8'h1C, 32'h4455_0000, "R2");

    // R6 compare with entry 3
    wr(8'h80, 32'h0000_0008);
    wr(8'h84, 32'h0000_0010);
    send(48'h0211_2233_4455, "R6");
    chk(match_idx == 4'd3 && accept, "R6", {59'd0, accept, match_idx}, {59'd0, 1'b1, 4'd3});
    // R10 hold between decisions
    repeat (3) @(negedge clk);
    chk(match_idx == 4'd3 && match_hit && !accept && !reject, "R10",
        {58'd0, match_hit, accept, match_idx}, {58'd0, 1'b1, 1'b0, 4'd3});

    // R3 enable controls matching; upper bits read zero
    wr(8'h80, 32'hFFFF_0000);
    rd(8'h80, 32'h0, "R3");
    send(48'h0211_2233_4455, "R3");
    chk(reject, "R3", 64'(reject), 64'd1);

    // R10 lowest index wins
    set_entry(7, 48'h0211_2233_4455);
    wr(8'h80, 32'h0000_0088);
    send(48'h0211_2233_4455, "R10");
    chk(match_idx == 4'd3, "R10", 64'(match_idx), 64'd3);

    // R7 inversion
    wr(8'h84, 32'h0000_0018);
    rd(8'h84, 32'h0000_0018, "R4");
    send(48'h0211_2233_4455, "R7");
    chk(reject, "R7", 64'(reject), 64'd1);
    send(48'h0011_2233_4456, "R7");
    chk(accept, "R7", 64'(accept), 64'd1);

    // R8 compare disabled
    wr(8'h84, 32'hFFFF_FFE0);
    rd(8'h84, 32'h0, "R4");
    send(48'h0211_2233_4455, "R8");
    chk(reject, "R8", 64'(reject), 64'd1);

    // R9 classes
    wr(8'h84, 32'h0000_0004);
    send(48'hFFFF_FFFF_FFFF, "R9");
    send(48'h0100_5E00_0001, "R9");
    wr(8'h84, 32'h0000_0002);
    send(48'hFFFF_FFFF_FFFF, "R9");
    send(48'h0100_5E00_0001, "R9");
    wr(8'h84, 32'h0000_0001);
    send(48'h0011_2233_4455, "R9");
    send(48'h0100_5E00_0001, "R9");

    // R11 unmapped and misaligned accesses
    set_entry(0, 48'h1234_5678_9ABC);
    wr(8'h01, 32'hDEAD_BEEF);
    wr(8'h88, 32'hDEAD_BEEF);
    wr(8'h06, 32'hDEAD_BEEF);
    rd(8'h00, 32'h1234_5678, "R11");
    rd(8'h04, 32'h9ABC_0000, "R11");
    rd(8'h88, 32'h0, "R11");
    rd(8'h01, 32'h0, "R11");
    rd(8'hFC, 32'h0, "R11");

    // random mix
    for (int it = 0; it < 400; it++) begin
      if (it % 25 == 0) begin
        for (int i = 0; i < N; i++) begin
          a = {$urandom, $urandom} & 48'hFEFF_FFFF_FFFF;
          if ($urandom_range(0, 3) == 0) a = 48'hFFFF_FFFF_FFFF;
          else if ($urandom_range(0, 2) == 0) a[40] = 1'b1;
          set_entry(i, a);
        end
        if ($urandom_range(0, 2) == 0) set_entry(int'($urandom_range(8, 15)), {hi_m[2], lo_m[2]});
        wr(8'h80, $urandom);
        wr(8'h84, $urandom);
      end
      case ($urandom_range(0, 3))
        0: a = {hi_m[$urandom_range(0, 15)], 16'h0};
        1: a = 48'hFFFF_FFFF_FFFF;
        default: a = {$urandom, $urandom};
      endcase
      if (a[15:0] == 16'h0) begin
        int k;
        k = int'($urandom_range(0, 15));
        a = {hi_m[k], lo_m[k]};
      end
      send(a, "R6 R7 R8 R9");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule